// File: doc/BRIEF.md
# Default Control Endpoint Handshake Responder

This block keeps the response state of a USB peripheral's default control endpoint and turns each decoded host token into a response decision for the packet engine. A two-bit response field chosen by software says whether the endpoint is blocked (NAK), ready to move data (BUF) or halted (STALL). Hardware events from the packet engine override that field: a bus reset or an arriving SETUP packet force NAK, and a sequence error or an oversized data packet force STALL.

When a SETUP packet arrives, the block raises a setup-pending flag. Until software clears that flag, software writes to the response field and attempts to set the status-completion bit have no effect, so a late write cannot undo the forced NAK. When software sets the status-completion bit while the field is BUF, the next status-stage token is answered on the block's own: an ACK for the host's OUT after a control read, or a zero-length packet for the host's IN after a control write or a no-data transfer. When the packet engine reports an address-assignment request, the block answers that whole transfer by itself and ignores the response field and the completion bit until the status IN has been answered.

The packet engine presents at most one token per cycle and receives one answer code in the following cycle. Software sees the response field, the pending and completion flags, a sticky stall indication and the automatic-mode flag as plain outputs.

Top module: `ep0_resp_ctrl`

## Requirements
- R1: After reset the response field is NAK (00), the setup-pending, completion, sticky-stall and automatic-mode flags are 0, and no answer is valid.
- R2: A software write to the response field with setup-pending at 0 sets the field to the written value after the next clock edge and clears the sticky-stall flag.
- R3: A SETUP event sets the field to NAK, sets setup-pending, clears the completion bit and records the transfer direction (setup_dir_in = 1 means a control read).
- R4: While setup-pending is 1, including the cycle in which software clears it, software writes to the response field and writes of 1 to the completion bit are ignored; a pending-clear request sets the flag to 0.
- R5: An overflow event while the field is BUF (01) sets the field to STALL 11 and sets the sticky-stall flag; an overflow event while the field is not BUF changes nothing.
- R6: A sequence-error event sets the field to STALL 10 and sets the sticky-stall flag.
- R7: A bus-reset event sets the field to NAK and clears setup-pending, completion and automatic mode; the sticky-stall flag is left as it was.
- R8: When events coincide in one cycle the result follows the order bus reset, SETUP, sequence error, overflow, software write, highest first.
- R9: A token presented in one cycle produces exactly one answer, with ans_valid high in the next cycle only; answer codes are 0 none, 1 NAK, 2 transfer data, 3 ACK, 4 zero-length packet, 5 STALL. Outside automatic mode a field of 00 gives NAK, 1x gives STALL, and 01 gives transfer data unless R10 applies.
- R10: With the field at BUF and the completion bit set, the status-stage token is answered by the block: OUT after a control read gives ACK, IN after a control write or no-data transfer gives a zero-length packet; the data-direction token still gives transfer data.
- R11: An address-request event starts automatic mode; in it an IN token gives a zero-length packet and an OUT token gives ACK whatever the field and completion bit hold; automatic mode ends after that IN, on a SETUP without an address request, or on bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_bus_reset | input | 1 | USB bus reset detected (pulse) |
| ev_setup | input | 1 | SETUP packet received (pulse) |
| setup_dir_in | input | 1 | Direction of the received setup, 1 for a control read; sampled with ev_setup |
| ev_seq_err | input | 1 | Control-transfer sequence error (pulse) |
| ev_overflow | input | 1 | Received data longer than the maximum packet size (pulse) |
| ev_set_addr | input | 1 | Address-assignment request detected (pulse) |
| tok_in | input | 1 | IN token to be answered (pulse) |
| tok_out | input | 1 | OUT token to be answered (pulse) |
| sw_resp_we | input | 1 | Software write strobe for the response field |
| sw_resp | input | 2 | Response value written by software |
| sw_cplt_we | input | 1 | Software write strobe for the completion bit |
| sw_cplt | input | 1 | Completion bit value written by software |
| sw_pend_clr | input | 1 | Software request to clear setup-pending |
| resp_field | output | 2 | Current response field (00 NAK, 01 BUF, 1x STALL) |
| setup_pend | output | 1 | Setup-pending flag |
| cplt_req | output | 1 | Status-completion bit |
| stall_seen | output | 1 | Sticky flag set when hardware forced STALL |
| auto_mode | output | 1 | Automatic address-transfer handling active |
| ans_valid | output | 1 | Answer code valid this cycle |
| ans_code | output | 3 | Answer to the packet engine |

## Verification
The assertions take for granted that tok_in and tok_out are never high together and that a token never shares a cycle with a SETUP or bus-reset event, since the packet engine handles one packet at a time; they also expect setup_dir_in to be meaningful only when ev_setup is high. The stimulus keeps to this: every table row and directed step carries at most one token, tokens stand in rows without SETUP or bus reset, and coinciding events are limited to the hardware-versus-hardware and hardware-versus-software collisions that the priority requirement names.

// File: rtl/ep0_resp_pkg.sv
package ep0_resp_pkg;

   localparam int RESP_W = 2;
   localparam int ANS_W  = 3;

   localparam logic [RESP_W-1:0] RESP_NAK = 2'b00;
   localparam logic [RESP_W-1:0] RESP_BUF = 2'b01;

   typedef enum logic [ANS_W-1:0] {
      ANS_NONE  = 3'd0,
      ANS_NAK   = 3'd1,
      ANS_XFER  = 3'd2,
      ANS_ACK   = 3'd3,
      ANS_ZLP   = 3'd4,
      ANS_STALL = 3'd5
   } ans_e;

   function automatic logic resp_is_stall(input logic [RESP_W-1:0] r);
      return r[RESP_W-1];
   endfunction

endpackage

// File: rtl/ep0_resp_field.sv
module ep0_resp_field
   import ep0_resp_pkg::*;
#(
   parameter logic [RESP_W-1:0] OVF_CODE = 2'b11,
   parameter logic [RESP_W-1:0] SEQ_CODE = 2'b10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rst,
   input  logic              setup,
   input  logic              seq_err,
   input  logic              overflow,
   input  logic              wr_en,
   input  logic [RESP_W-1:0] wr_val,
   input  logic              wr_open,
   output logic [RESP_W-1:0] resp,
   output logic              stall_flag
);

   logic [RESP_W-1:0] resp_d;
   logic              flag_d;
   logic              ovf_hit;

   assign ovf_hit = overflow && (resp == RESP_BUF);

   always_comb begin
      resp_d = resp;
      flag_d = stall_flag;
      if (bus_rst) begin
         resp_d = RESP_NAK;
      end else if (setup) begin
         resp_d = RESP_NAK;
      end else if (seq_err) begin
         resp_d = SEQ_CODE;
         flag_d = 1'b1;
      end else if (ovf_hit) begin
         resp_d = OVF_CODE;
         flag_d = 1'b1;
      end else if (wr_en && wr_open) begin
         resp_d = wr_val;
         flag_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp       <= RESP_NAK;
         stall_flag <= 1'b0;
      end else begin
         resp       <= resp_d;
         stall_flag <= flag_d;
      end
   end

endmodule

// File: rtl/ep0_setup_track.sv
module ep0_setup_track (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_rst,
   input  logic setup,
   input  logic setup_dir,
   input  logic set_addr,
   input  logic in_tok,
   input  logic cplt_we,
   input  logic cplt_val,
   input  logic pend_clr,
   output logic pend,
   output logic cplt,
   output logic ctrl_read,
   output logic auto_on
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
      end else if (bus_rst) begin
         pend <= 1'b0;
      end else if (setup) begin
         pend <= 1'b1;
      end else if (pend_clr) begin
         pend <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cplt <= 1'b0;
      end else if (bus_rst || setup) begin
         cplt <= 1'b0;
      end else if (cplt_we && (!cplt_val || !pend)) begin
         cplt <= cplt_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_read <= 1'b0;
      end else if (setup) begin
         ctrl_read <= setup_dir;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         auto_on <= 1'b0;
      end else if (bus_rst) begin
         auto_on <= 1'b0;
      end else if (set_addr) begin
         auto_on <= 1'b1;
      end else if (setup) begin
         auto_on <= 1'b0;
      end else if (in_tok && auto_on) begin
         auto_on <= 1'b0;
      end
   end

endmodule

// File: rtl/ep0_answer.sv
module ep0_answer
   import ep0_resp_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RESP_W-1:0] resp,
   input  logic              cplt,
   input  logic              ctrl_read,
   input  logic              auto_on,
   input  logic              in_tok,
   input  logic              out_tok,
   output logic              valid,
   output logic [ANS_W-1:0]  code
);

   ans_e ans_c;
   logic status_tok;

   assign status_tok = (ctrl_read && out_tok) || (!ctrl_read && in_tok);

   always_comb begin
      if (!(in_tok || out_tok)) begin
         ans_c = ANS_NONE;
      end else if (auto_on) begin
         ans_c = in_tok ? ANS_ZLP : ANS_ACK;
      end else if (resp_is_stall(resp)) begin
         ans_c = ANS_STALL;
      end else if (resp == RESP_NAK) begin
         ans_c = ANS_NAK;
      end else if (cplt && status_tok) begin
         ans_c = in_tok ? ANS_ZLP : ANS_ACK;
      end else begin
         ans_c = ANS_XFER;
      end
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               valid <= 1'b0;
               code  <= ANS_NONE;
            end else begin
               valid <= in_tok || out_tok;
               code  <= ans_c;
            end
         end
      end else begin : g_comb
         assign valid = in_tok || out_tok;
         assign code  = ans_c;
      end
   endgenerate

endmodule

// File: rtl/ep0_resp_ctrl.sv
module ep0_resp_ctrl
   import ep0_resp_pkg::*;
#(
   parameter logic [1:0] OVF_CODE = 2'b11,
   parameter logic [1:0] SEQ_CODE = 2'b10,
   parameter bit         REG_OUT  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_bus_reset,
   input  logic       ev_setup,
   input  logic       setup_dir_in,
   input  logic       ev_seq_err,
   input  logic       ev_overflow,
   input  logic       ev_set_addr,
   input  logic       tok_in,
   input  logic       tok_out,
   input  logic       sw_resp_we,
   input  logic [1:0] sw_resp,
   input  logic       sw_cplt_we,
   input  logic       sw_cplt,
   input  logic       sw_pend_clr,
   output logic [1:0] resp_field,
   output logic       setup_pend,
   output logic       cplt_req,
   output logic       stall_seen,
   output logic       auto_mode,
   output logic       ans_valid,
   output logic [2:0] ans_code
);

   generate
      if (!OVF_CODE[RESP_W-1]) begin : g_bad_ovf
         $error("OVF_CODE must be a STALL encoding (upper bit set)");
      end
      if (!SEQ_CODE[RESP_W-1]) begin : g_bad_seq
         $error("SEQ_CODE must be a STALL encoding (upper bit set)");
      end
   endgenerate

   logic ctrl_read_q;

   ep0_setup_track u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rst   (ev_bus_reset),
      .setup     (ev_setup),
      .setup_dir (setup_dir_in),
      .set_addr  (ev_set_addr),
      .in_tok    (tok_in),
      .cplt_we   (sw_cplt_we),
      .cplt_val  (sw_cplt),
      .pend_clr  (sw_pend_clr),
      .pend      (setup_pend),
      .cplt      (cplt_req),
      .ctrl_read (ctrl_read_q),
      .auto_on   (auto_mode)
   );

   ep0_resp_field #(
      .OVF_CODE (OVF_CODE),
      .SEQ_CODE (SEQ_CODE)
   ) u_field (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_rst    (ev_bus_reset),
      .setup      (ev_setup),
      .seq_err    (ev_seq_err),
      .overflow   (ev_overflow),
      .wr_en      (sw_resp_we),
      .wr_val     (sw_resp),
      .wr_open    (!setup_pend),
      .resp       (resp_field),
      .stall_flag (stall_seen)
   );

   ep0_answer #(
      .REG_OUT (REG_OUT)
   ) u_answer (
      .clk       (clk),
      .rst_n     (rst_n),
      .resp      (resp_field),
      .cplt      (cplt_req),
      .ctrl_read (ctrl_read_q),
      .auto_on   (auto_mode),
      .in_tok    (tok_in),
      .out_tok   (tok_out),
      .valid     (ans_valid),
      .code      (ans_code)
   );

endmodule

// File: rtl/ep0_resp_chk.sv
module ep0_resp_chk #(
   parameter logic [1:0] OVF_CODE = 2'b11,
   parameter logic [1:0] SEQ_CODE = 2'b10,
   parameter bit         REG_OUT  = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ev_bus_reset,
   input logic       ev_setup,
   input logic       ev_seq_err,
   input logic       ev_overflow,
   input logic       ev_set_addr,
   input logic       tok_in,
   input logic       tok_out,
   input logic       sw_resp_we,
   input logic       sw_cplt_we,
   input logic       sw_cplt,
   input logic [1:0] resp_field,
   input logic       setup_pend,
   input logic       cplt_req,
   input logic       stall_seen,
   input logic       auto_mode,
   input logic       ctrl_read,
   input logic       ans_valid,
   input logic [2:0] ans_code
);

   a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (resp_field == 2'b00 && !setup_pend && !cplt_req
                        && !stall_seen && !auto_mode && !ans_valid));

   a_r3_setup_forces_nak: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_setup && !ev_bus_reset) |=> (resp_field == 2'b00 && setup_pend && !cplt_req));

   a_r4_locked_field: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_pend && sw_resp_we && !ev_bus_reset && !ev_setup && !ev_seq_err && !ev_overflow)
      |=> $stable(resp_field));

   a_r4_locked_cplt: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_pend && sw_cplt_we && sw_cplt && !cplt_req) |=> !cplt_req);

   a_r5_overflow_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_overflow && resp_field == 2'b01 && !ev_bus_reset && !ev_setup && !ev_seq_err)
      |=> (resp_field == OVF_CODE && stall_seen));

   a_r6_seq_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_seq_err && !ev_bus_reset && !ev_setup) |=> (resp_field == SEQ_CODE && stall_seen));

   a_r7_bus_reset: assert property (@(posedge clk) disable iff (!rst_n)
      ev_bus_reset |=> (resp_field == 2'b00 && !setup_pend && !cplt_req && !auto_mode));

   generate
      if (REG_OUT) begin : g_reg_chk
         a_r9_answer_follows_token: assert property (@(posedge clk) disable iff (!rst_n)
            (tok_in || tok_out) |=> ans_valid);

         a_r9_no_spurious_answer: assert property (@(posedge clk) disable iff (!rst_n)
            !(tok_in || tok_out) |=> !ans_valid);

         a_r10_status_zlp: assert property (@(posedge clk) disable iff (!rst_n)
            (tok_in && !auto_mode && !ctrl_read && cplt_req && resp_field == 2'b01)
            |=> ans_code == 3'd4);

         a_r11_auto_in_zlp: assert property (@(posedge clk) disable iff (!rst_n)
            (tok_in && auto_mode) |=> (ans_code == 3'd4 && !auto_mode));
      end
   endgenerate

   a_r11_start_auto: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_set_addr && !ev_bus_reset) |=> auto_mode);

endmodule

bind ep0_resp_ctrl ep0_resp_chk #(
   .OVF_CODE (OVF_CODE),
   .SEQ_CODE (SEQ_CODE),
   .REG_OUT  (REG_OUT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ev_bus_reset (ev_bus_reset),
   .ev_setup     (ev_setup),
   .ev_seq_err   (ev_seq_err),
   .ev_overflow  (ev_overflow),
   .ev_set_addr  (ev_set_addr),
   .tok_in       (tok_in),
   .tok_out      (tok_out),
   .sw_resp_we   (sw_resp_we),
   .sw_cplt_we   (sw_cplt_we),
   .sw_cplt      (sw_cplt),
   .resp_field   (resp_field),
   .setup_pend   (setup_pend),
   .cplt_req     (cplt_req),
   .stall_seen   (stall_seen),
   .auto_mode    (auto_mode),
   .ctrl_read    (ctrl_read_q),
   .ans_valid    (ans_valid),
   .ans_code     (ans_code)
);

// File: tb/test_ep0_resp_ctrl.sv
module test_ep0_resp_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_bus_reset = 1'b0, ev_setup = 1'b0, setup_dir_in = 1'b0;
   logic       ev_seq_err = 1'b0, ev_overflow = 1'b0, ev_set_addr = 1'b0;
   logic       tok_in = 1'b0, tok_out = 1'b0;
   logic       sw_resp_we = 1'b0, sw_cplt_we = 1'b0, sw_cplt = 1'b0, sw_pend_clr = 1'b0;
   logic [1:0] sw_resp = 2'b00;
   logic [1:0] resp_field;
   logic       setup_pend, cplt_req, stall_seen, auto_mode, ans_valid;
   logic [2:0] ans_code;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   ep0_resp_ctrl i_ep0_resp_ctrl (
      .clk, .rst_n, .ev_bus_reset, .ev_setup, .setup_dir_in, .ev_seq_err,
      .ev_overflow, .ev_set_addr, .tok_in, .tok_out, .sw_resp_we, .sw_resp,
      .sw_cplt_we, .sw_cplt, .sw_pend_clr, .resp_field, .setup_pend, .cplt_req,
      .stall_seen, .auto_mode, .ans_valid, .ans_code
   );

   typedef struct packed {
      logic       rst, stp, dir, seq, ovf, sa, tin, tout, swe;
      logic [1:0] swr;
      logic       cwe, cv, pclr;
      logic [1:0] e_resp;
      logic       e_pend, e_cplt, e_stall, e_auto;
      logic [2:0] e_ans;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 35;
   // Columns: rst stp dir seq ovf sa tin tout swe swr cwe cv pclr | resp pend cplt stall auto ans | req
   localparam vec_t TBL [0:NV-1] = '{
      '{0,0,0,0,0,0,0,0,1,2'b01,0,0,0, 2'b01,0,0,0,0,3'd0, 4'd2},  // R2 write BUF
      '{0,0,0,0,0,0,1,0,0,2'b00,0,0,0, 2'b01,0,0,0,0,3'd2, 4'd9},  // R9 IN with BUF
      '{0,0,0,0,1,0,0,0,0,2'b00,0,0,0, 2'b11,0,0,1,0,3'd0, 4'd5},  // R5 overflow
      '{0,0,0,0,0,0,0,1,0,2'b00,0,0,0, 2'b11,0,0,1,0,3'd5, 4'd9},  // R9 STALL answer
      '{0,0,0,0,0,0,0,0,1,2'b01,0,0,0, 2'b01,0,0,0,0,3'd0, 4'd2},  // R2 clears sticky
      '{0,1,1,0,0,0,0,0,0,2'b00,0,0,0, 2'b00,1,0,0,0,3'd0, 4'd3},  // R3 setup, read
      '{0,0,0,0,0,0,0,0,1,2'b01,0,0,0, 2'b00,1,0,0,0,3'd0, 4'd4},  // R4 field locked
      '{0,0,0,0,0,0,0,0,0,2'b00,1,1,0, 2'b00,1,0,0,0,3'd0, 4'd4},  // R4 cplt locked
      '{0,0,0,0,0,0,1,0,0,2'b00,0,0,0, 2'b00,1,0,0,0,3'd1, 4'd9},  // R9 NAK answer
      '{0,0,0,0,0,0,0,0,0,2'b00,0,0,1, 2'b00,0,0,0,0,3'd0, 4'd4},  // R4 pending cleared
      '{0,0,0,0,0,0,0,0,1,2'b01,0,0,0, 2'b01,0,0,0,0,3'd0, 4'd2},  // R2
      '{0,0,0,0,0,0,0,0,0,2'b00,1,1,0, 2'b01,0,1,0,0,3'd0, 4'd10}, // R10 set cplt
      '{0,0,0,0,0,0,1,0,0,2'b00,0,0,0, 2'b01,0,1,0,0,3'd2, 4'd10}, // R10 data IN
      '{0,0,0,0,0,0,0,1,0,2'b00,0,0,0, 2'b01,0,1,0,0,3'd3, 4'd10}, // R10 status OUT ACK
      '{0,1,0,0,0,0,0,0,0,2'b00,0,0,0, 2'b00,1,0,0,0,3'd0, 4'd3},  // R3 clears cplt
      '{0,0,0,0,0,0,0,0,1,2'b01,0,0,1, 2'b00,0,0,0,0,3'd0, 4'd4},  // R4 same-cycle clear
      '{0,0,0,0,0,0,0,0,1,2'b01,1,1,0, 2'b01,0,1,0,0,3'd0, 4'd10}, // R10
      '{0,0,0,0,0,0,1,0,0,2'b00,0,0,0, 2'b01,0,1,0,0,3'd4, 4'd10}, // R10 status IN ZLP
      '{0,0,0,0,0,0,0,1,0,2'b00,0,0,0, 2'b01,0,1,0,0,3'd2, 4'd10}, // R10 data OUT
      '{0,0,0,1,0,0,0,0,1,2'b00,0,0,0, 2'b10,0,1,1,0,3'd0, 4'd8},  // R8 seq beats sw
      '{0,0,0,0,1,0,0,0,0,2'b00,0,0,0, 2'b10,0,1,1,0,3'd0, 4'd5},  // R5 ovf not BUF
      '{0,0,0,0,0,0,0,0,1,2'b01,0,0,0, 2'b01,0,1,0,0,3'd0, 4'd2},  // R2
      '{0,0,0,1,1,0,0,0,0,2'b00,0,0,0, 2'b10,0,1,1,0,3'd0, 4'd8},  // R8 seq beats ovf
      '{0,1,0,1,0,0,0,0,0,2'b00,0,0,0, 2'b00,1,0,1,0,3'd0, 4'd8},  // R8 setup beats seq
      '{1,1,0,0,0,0,0,0,0,2'b00,0,0,0, 2'b00,0,0,1,0,3'd0, 4'd7},  // R7 reset beats setup
      '{0,1,0,0,0,1,0,0,0,2'b00,0,0,0, 2'b00,1,0,1,1,3'd0, 4'd11}, // R11 start auto
      '{0,0,0,0,0,0,0,1,0,2'b00,0,0,0, 2'b00,1,0,1,1,3'd3, 4'd11}, // R11 OUT ACK
      '{0,0,0,0,0,0,1,0,0,2'b00,0,0,0, 2'b00,1,0,1,0,3'd4, 4'd11}, // R11 IN ZLP, ends
      '{0,0,0,0,0,0,1,0,0,2'b00,0,0,0, 2'b00,1,0,1,0,3'd1, 4'd11}, // R11 back to field
      '{0,1,0,0,0,1,0,0,0,2'b00,0,0,0, 2'b00,1,0,1,1,3'd0, 4'd11}, // R11
      '{1,0,0,0,0,0,0,0,0,2'b00,0,0,0, 2'b00,0,0,1,0,3'd0, 4'd7},  // R7 clears auto
      '{0,0,0,0,0,0,0,0,1,2'b10,0,0,0, 2'b10,0,0,0,0,3'd0, 4'd2},  // R2 sw STALL
      '{0,0,0,0,0,0,1,0,0,2'b00,0,0,0, 2'b10,0,0,0,0,3'd5, 4'd9},  // R9 1x gives STALL
      '{0,0,0,0,0,0,0,0,1,2'b01,0,0,0, 2'b01,0,0,0,0,3'd0, 4'd2},  // R2
      '{0,0,0,0,1,0,0,0,1,2'b00,0,0,0, 2'b11,0,0,1,0,3'd0, 4'd8}   // R8 ovf beats sw
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      ev_bus_reset = v.rst; ev_setup = v.stp; setup_dir_in = v.dir;
      ev_seq_err = v.seq; ev_overflow = v.ovf; ev_set_addr = v.sa;
      tok_in = v.tin; tok_out = v.tout; sw_resp_we = v.swe; sw_resp = v.swr;
      sw_cplt_we = v.cwe; sw_cplt = v.cv; sw_pend_clr = v.pclr;
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
      apply('0);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog all-requirements actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1 reset state
      check("R1 resp", resp_field, 2'b00);
      check("R1 flags", {setup_pend, cplt_req, stall_seen, auto_mode, ans_valid}, 5'b0);

      for (int i = 0; i < NV; i++) begin
         apply(TBL[i]);
         tick();
         check($sformatf("R%0d row%0d resp", TBL[i].req, i), resp_field, TBL[i].e_resp);
         check($sformatf("R%0d row%0d flags", TBL[i].req, i),
               {setup_pend, cplt_req, stall_seen, auto_mode},
               {TBL[i].e_pend, TBL[i].e_cplt, TBL[i].e_stall, TBL[i].e_auto});
         check($sformatf("R%0d row%0d answer", TBL[i].req, i),
               {ans_valid, ans_code}, {TBL[i].e_ans != 3'd0, TBL[i].e_ans});
      end

      // R9: answer lasts one cycle only
      tick();
      check("R9 answer one cycle", ans_valid, 1'b0);

      // R6: sequence error from BUF gives code 10
      sw_resp_we = 1'b1; sw_resp = 2'b01;
      tick();
      ev_seq_err = 1'b1;
      tick();
      check("R6 seq stall code", resp_field, 2'b10);
      check("R6 sticky", stall_seen, 1'b1);

      // R1: asynchronous reset mid-run returns to idle
      ev_setup = 1'b1; ev_set_addr = 1'b1;
      tick();
      #3 rst_n = 1'b0;
      #3;
      check("R1 reset resp", resp_field, 2'b00);
      check("R1 reset flags", {setup_pend, cplt_req, stall_seen, auto_mode, ans_valid}, 5'b0);
      @(posedge clk);
      #2 rst_n = 1'b1;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule